// File: doc/BRIEF.md
# Line Segment Pixel Stepper

This block turns a pair of integer screen endpoints into the ordered list of pixel addresses that approximate the straight segment between them. After a one-cycle start strobe it latches the endpoints, folds the segment into a canonical shallow, rising form, and then emits one pixel address per clock. The first address is the start point and the last is the end point. A one-cycle completion pulse follows the last pixel.

Two incremental accumulators do the work. A line accumulator holds the signed distance term of the segment's equation and decides, pixel by pixel, whether the minor axis advances. A pixel accumulator counts the addresses already produced and is compared against a length fixed when the start strobe is accepted. The decision logic knows only the canonical octant. A three-bit octant code then maps each canonical step back onto the real screen directions.

Top module: `vec_raster`

## Requirements
- R1: While reset is held and in the first cycle after reset, `pix_valid` and `done` are both 0.
- R2: When `start` is sampled high while the block is idle, `pix_valid` is 1 in every cycle from the next cycle until the last pixel, with no gap.
- R3: The first emitted address equals (`x0`,`y0`) as sampled with the accepted strobe. Later changes on the endpoint inputs have no effect on the vector in flight.
- R4: The number of emitted pixels is max(|x1-x0|,|y1-y0|)+1, and the last address equals (`x1`,`y1`).
- R5: Between consecutive emitted pixels, the major-axis coordinate moves by exactly one and the minor-axis coordinate moves by zero or one.
- R6: The octant code has three parts. The swap flag is 1 when |dy|>|dx|, in which case Y is the major axis. The X-negate flag is 1 when x1<x0, and the Y-negate flag is 1 when y1<y0. At major step i, the minor offset from the start is floor((2*i*dmin + dmaj)/(2*dmaj)), where dmaj and dmin are the larger and smaller absolute deltas. This is the result of an error term that starts at 2*dmin-dmaj, gains 2*dmin per step and loses 2*dmaj whenever it is non-negative.
- R7: `done` is high for exactly one cycle, the cycle right after the last pixel, and `pix_valid` is 0 in that cycle.
- R8: A vector whose endpoints coincide emits exactly one pixel, then pulses `done`.
- R9: A `start` strobe that arrives while pixels are being emitted, or in the `done` cycle, is ignored. No pixel follows the `done` cycle unless a new strobe arrives while the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a vector; endpoints are sampled with it |
| x0 | input | COORD_W | Start point X |
| y0 | input | COORD_W | Start point Y |
| x1 | input | COORD_W | End point X |
| y1 | input | COORD_W | End point Y |
| pix_valid | output | 1 | Current pixel address is valid |
| pix_x | output | COORD_W | Pixel X address |
| pix_y | output | COORD_W | Pixel Y address |
| done | output | 1 | One-cycle pulse after the last pixel |

## Verification
Every end point inside an 11-by-11 square around two different start points is drawn. This covers all eight octants, both exact diagonals, pure horizontal and vertical runs, and the coincident-endpoint case. Each pixel is compared with a closed-form rounding formula rather than a stepped error term, so a wrong tie rule, a wrong fold sign or a swapped axis shows up as a wrong coordinate. Collisions in pixel count are caught at the `done` position. Selected vectors carry a second strobe during drawing and in the `done` cycle, and the endpoint inputs change after acceptance; both separate correct latching from a restart.

// File: rtl/vr_pkg.sv
// Shared types for the line segment stepper.
// Assumes nothing beyond a common clock domain.
package vr_pkg;
    // Octant fold code: axis swap plus the two screen-direction negations
    typedef struct packed {
        logic swap;
        logic negx;
        logic negy;
    } vr_oct_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_DRAW = 2'd1,
        ST_FIN  = 2'd2
    } vr_state_e;
endpackage

// File: rtl/vr_fold.sv
// Folds a segment into the first octant.
// Produces the octant code and the major/minor absolute deltas.
// Purely combinational; endpoints are unsigned screen coordinates.
module vr_fold
    import vr_pkg::*;
#(
    parameter int COORD_W = 12
) (
    input  logic [COORD_W-1:0] ax,
    input  logic [COORD_W-1:0] ay,
    input  logic [COORD_W-1:0] bx,
    input  logic [COORD_W-1:0] by,
    output vr_oct_t            oct,
    output logic [COORD_W-1:0] dmaj,
    output logic [COORD_W-1:0] dmin
);
    localparam int SD_W = COORD_W + 1;

    logic signed [SD_W-1:0] sdx, sdy;
    logic [SD_W-1:0]        absx_w, absy_w;
    logic [COORD_W-1:0]     absx, absy;

    // Signed deltas and their magnitudes
    always_comb begin
        sdx    = $signed({1'b0, bx}) - $signed({1'b0, ax});
        sdy    = $signed({1'b0, by}) - $signed({1'b0, ay});
        absx_w = sdx[SD_W-1] ? SD_W'(-sdx) : SD_W'(sdx);
        absy_w = sdy[SD_W-1] ? SD_W'(-sdy) : SD_W'(sdy);
        absx   = absx_w[COORD_W-1:0];
        absy   = absy_w[COORD_W-1:0];
    end

    // Octant code and the canonical deltas
    always_comb begin
        oct.swap = (absy > absx);
        oct.negx = sdx[SD_W-1];
        oct.negy = sdy[SD_W-1];
        dmaj     = oct.swap ? absy : absx;
        dmin     = oct.swap ? absx : absy;
    end
endmodule

// File: rtl/vr_line_acc.sv
// Line-equation accumulator working in first-octant form.
// Signals a minor-axis step whenever the error term is non-negative.
// Assumes load and step are never high together.
module vr_line_acc #(
    parameter int COORD_W = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic               step,
    input  logic [COORD_W-1:0] dmaj,
    input  logic [COORD_W-1:0] dmin,
    output logic               minor_go
);
    localparam int ERR_W = COORD_W + 3;

    logic signed [ERR_W-1:0] err_q;
    logic signed [ERR_W-1:0] inc_maj_q;   // 2*dmin
    logic signed [ERR_W-1:0] dec_min_q;   // 2*dmaj

    assign minor_go = ~err_q[ERR_W-1];

    // Load the initial term or advance it by one major step
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q     <= '0;
            inc_maj_q <= '0;
            dec_min_q <= '0;
        end else if (load) begin
            inc_maj_q <= $signed({2'b00, dmin, 1'b0});
            dec_min_q <= $signed({2'b00, dmaj, 1'b0});
            err_q     <= $signed({2'b00, dmin, 1'b0}) - $signed({3'b000, dmaj});
        end else if (step) begin
            err_q <= minor_go ? (err_q + inc_maj_q - dec_min_q) : (err_q + inc_maj_q);
        end
    end
endmodule

// File: rtl/vr_pix_cnt.sv
// Pixel-count accumulator: counts emitted pixels against a preloaded total.
// last is high while the current pixel is the final one.
module vr_pix_cnt #(
    parameter int COORD_W = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic               step,
    input  logic [COORD_W-1:0] target,
    output logic               last
);
    logic [COORD_W-1:0] cnt_q, tgt_q;

    assign last = (cnt_q == tgt_q);

    // Clear on load, count one per emitted non-final pixel
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            tgt_q <= '0;
        end else if (load) begin
            cnt_q <= '0;
            tgt_q <= target;
        end else if (step) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/vec_raster.sv
// Line segment stepper top: one pixel address per clock between two endpoints.
// Sequencing: idle -> draw (dmaj+1 cycles) -> one done cycle -> idle.
// Assumes integer endpoints; start is only honoured while idle.
module vec_raster
    import vr_pkg::*;
#(
    parameter int COORD_W = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [COORD_W-1:0] x0,
    input  logic [COORD_W-1:0] y0,
    input  logic [COORD_W-1:0] x1,
    input  logic [COORD_W-1:0] y1,
    output logic               pix_valid,
    output logic [COORD_W-1:0] pix_x,
    output logic [COORD_W-1:0] pix_y,
    output logic               done
);
    vr_state_e          state_q;
    vr_oct_t            oct_w, oct_q;
    logic [COORD_W-1:0] dmaj_w, dmin_w;
    logic [COORD_W-1:0] cur_x_q, cur_y_q;
    logic               load, step, last, minor_go;
    logic               x_move, y_move;

    vr_fold #(.COORD_W(COORD_W)) fold_i (
        .ax(x0), .ay(y0), .bx(x1), .by(y1),
        .oct(oct_w), .dmaj(dmaj_w), .dmin(dmin_w)
    );

    vr_line_acc #(.COORD_W(COORD_W)) line_i (
        .clk(clk), .rst_n(rst_n), .load(load), .step(step),
        .dmaj(dmaj_w), .dmin(dmin_w), .minor_go(minor_go)
    );

    vr_pix_cnt #(.COORD_W(COORD_W)) cnt_i (
        .clk(clk), .rst_n(rst_n), .load(load), .step(step),
        .target(dmaj_w), .last(last)
    );

    // Control strobes and the unfold of canonical steps to screen axes
    always_comb begin
        load   = (state_q == ST_IDLE) && start;
        step   = (state_q == ST_DRAW) && !last;
        x_move = step && (!oct_q.swap || minor_go);
        y_move = step && ( oct_q.swap || minor_go);
    end

    // Sequencer state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            case (state_q)
                ST_IDLE: if (start) state_q <= ST_DRAW;
                ST_DRAW: if (last)  state_q <= ST_FIN;
                default:            state_q <= ST_IDLE;
            endcase
        end
    end

    // Current pixel address and latched octant code
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_x_q <= '0;
            cur_y_q <= '0;
            oct_q   <= '0;
        end else if (load) begin
            cur_x_q <= x0;
            cur_y_q <= y0;
            oct_q   <= oct_w;
        end else begin
            if (x_move) cur_x_q <= oct_q.negx ? cur_x_q - 1'b1 : cur_x_q + 1'b1;
            if (y_move) cur_y_q <= oct_q.negy ? cur_y_q - 1'b1 : cur_y_q + 1'b1;
        end
    end

    assign pix_valid = (state_q == ST_DRAW);
    assign pix_x     = cur_x_q;
    assign pix_y     = cur_y_q;
    assign done      = (state_q == ST_FIN);
endmodule

// File: rtl/vr_checker.sv
// Port-level checker for vec_raster, bound to every instance.
module vr_checker #(
    parameter int COORD_W = 12
) (
    input logic               clk,
    input logic               rst_n,
    input logic               start,
    input logic               pix_valid,
    input logic [COORD_W-1:0] pix_x,
    input logic [COORD_W-1:0] pix_y,
    input logic               done
);
    logic [COORD_W-1:0] prev_x, prev_y;
    logic               prev_valid;
    logic [COORD_W-1:0] ddx, ddy;
    logic               unit_x, unit_y;

    // Remember the previous sampled pixel
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_x     <= '0;
            prev_y     <= '0;
            prev_valid <= 1'b0;
        end else begin
            prev_x     <= pix_x;
            prev_y     <= pix_y;
            prev_valid <= pix_valid;
        end
    end

    always_comb begin
        ddx    = pix_x - prev_x;
        ddy    = pix_y - prev_y;
        unit_x = (ddx == '0) || (ddx == COORD_W'(1)) || (ddx == '1);
        unit_y = (ddy == '0) || (ddy == COORD_W'(1)) || (ddy == '1);
    end

    AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |=> !pix_valid && !done); // R1
    AST_STEP_UNIT: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid && prev_valid |-> unit_x && unit_y && (ddx != '0 || ddy != '0)); // R5
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R7
    AST_DONE_NO_PIX: assert property (@(posedge clk) disable iff (!rst_n) done |-> !pix_valid); // R7
    AST_DONE_AFTER_PIX: assert property (@(posedge clk) disable iff (!rst_n) done |-> prev_valid); // R7
    AST_NO_PIX_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !pix_valid); // R9
endmodule

bind vec_raster vr_checker #(.COORD_W(COORD_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .start(start), .pix_valid(pix_valid),
    .pix_x(pix_x), .pix_y(pix_y), .done(done)
);

// File: tb/vec_raster_tb_top.sv
module vec_raster_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int W = 12;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [W-1:0] x0 = '0, y0 = '0, x1 = '0, y1 = '0;
    logic         pix_valid, done;
    logic [W-1:0] pix_x, pix_y;

    int n_checks = 0;
    int n_bad    = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vec_raster #(.COORD_W(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start),
        .x0(x0), .y0(y0), .x1(x1), .y1(y1),
        .pix_valid(pix_valid), .pix_x(pix_x), .pix_y(pix_y), .done(done)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    // Draw one vector; poke adds ignored strobes during drawing and in the done cycle
    task automatic run_vec(input int ax, input int ay, input int bx, input int by, input bit poke);
        int dx, dy, sx, sy, adx, ady, dmaj, dmin, m, ex, ey;
        bit swp;
        dx = bx - ax; dy = by - ay;
        sx = (dx < 0) ? -1 : 1;  sy = (dy < 0) ? -1 : 1;
        adx = (dx < 0) ? -dx : dx; ady = (dy < 0) ? -dy : dy;
        swp = (ady > adx);                                   // R6 octant swap flag
        dmaj = swp ? ady : adx;  dmin = swp ? adx : ady;
        @(negedge clk);
        x0 = W'(ax); y0 = W'(ay); x1 = W'(bx); y1 = W'(by); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        x0 = W'(ax + 3); y0 = W'(ay + 2); x1 = W'(bx + 1); y1 = W'(by + 4);  // R3 inputs change after accept
        for (int i = 0; i <= dmaj; i++) begin
            m  = (dmaj == 0) ? 0 : (2 * i * dmin + dmaj) / (2 * dmaj);
            ex = swp ? ax + sx * m : ax + sx * i;
            ey = swp ? ay + sy * i : ay + sy * m;
            check(pix_valid == 1'b1, "R2 valid", int'(pix_valid), 1);
            if (i == 0) begin
                check(pix_x == W'(ex) && pix_y == W'(ey), "R3 first",
                      int'(pix_x) * 10000 + int'(pix_y), ex * 10000 + ey);
            end else if (i == dmaj) begin
                check(pix_x == W'(ex) && pix_y == W'(ey), "R4 last",
                      int'(pix_x) * 10000 + int'(pix_y), ex * 10000 + ey);
            end else begin
                check(pix_x == W'(ex) && pix_y == W'(ey), "R6 step",
                      int'(pix_x) * 10000 + int'(pix_y), ex * 10000 + ey);
            end
            if (poke && i == 0) begin
                start = 1'b1;                                // R9 strobe while drawing
                x0 = W'(ax + 7); y0 = W'(ay + 7);
            end
            @(negedge clk);
            start = 1'b0;
        end
        if (dmaj == 0) check(done == 1'b1 && pix_valid == 1'b0, "R8 zero-length done", int'(done), 1);
        check(done == 1'b1 && pix_valid == 1'b0, "R7 done after last", int'(done), 1);
        if (poke) start = 1'b1;                              // R9 strobe in done cycle
        @(negedge clk);
        start = 1'b0;
        check(done == 1'b0, "R7 single-cycle done", int'(done), 0);
        check(pix_valid == 1'b0, "R9 no pixel after done", int'(pix_valid), 0);
        @(negedge clk);
        check(pix_valid == 1'b0, "R9 strobe in done cycle ignored", int'(pix_valid), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(pix_valid == 1'b0 && done == 1'b0, "R1 reset quiet", int'(pix_valid) + int'(done), 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(pix_valid == 1'b0 && done == 1'b0, "R1 idle after reset", int'(pix_valid) + int'(done), 0);
        for (int c = 0; c < 2; c++) begin
            int cx, cy;
            cx = (c == 0) ? 20 : 5;
            cy = (c == 0) ? 20 : 40;
            for (int ox = -5; ox <= 5; ox++)
                for (int oy = -5; oy <= 5; oy++)
                    run_vec(cx, cy, cx + ox, cy + oy, ((ox + oy) % 3) == 0);
        end
        run_vec(100, 50, 100, 50, 1'b1);                     // R8 coincident endpoints
        run_vec(0, 0, 37, 11, 1'b1);
        run_vec(60, 60, 49, 23, 1'b0);
        $display("test done: total=%0d bad=%0d", n_checks, n_bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        n_checks++;
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", n_checks, n_bad);
        $finish;
    end
endmodule